// File: doc/BRIEF.md
# Thermal Throttle Request Monitor

This block sits behind an active-low, shared hot/throttle pin. Either the chip itself or an outside agent, for example a monitor on a voltage regulator, can pull the pin low. The block drives the pin low through a pull-down enable whenever the internal over-temperature flag calls for it. It also senses the pin level through a synchronizer. From that level it keeps a throttle-control output active for as long as anyone holds the pin asserted, and it produces optional single-cycle interrupt pulses on the assertion and release edges.

Rapid toggling of the pin is treated as a fault. A second synchronized pin edge within a 1.5 ms window sets a sticky request for the lowest performance state. The window is counted in microsecond ticks. Only reset or a software clear input removes that request.

The pull-down also follows the package idle state:
- **Active:** the pull-down tracks the internal flag.
- **Shallow and mid idle states:** a pull-down already in force at entry is held. It is dropped once the temperature falls below the trip point or the package returns to active. A new assertion is not started while in these states.
- **Deepest idle state:** the pin is released for as long as the package stays there.

Top module: `thm_hot_pin_monitor`

## Requirements
- R1: `throttle_o` becomes 1 on the third rising clock edge after `pin_in` goes low. It stays 1 while `pin_in` is low, for any length of time, and returns to 0 on the third edge after `pin_in` goes high. This assumes `overtemp_i` is 0.
- R2: When `overtemp_i` is 1, `throttle_o` is 1 one clock edge later, whatever the level of `pin_in`.
- R3: With `idle_state_i` = 00 (active), `pin_pulldown_o` equals `overtemp_i` one clock edge later.
- R4: With `idle_state_i` = 01 (C3) or 10 (C6), `pin_pulldown_o` stays 1 only while it was already 1 and `overtemp_i` stays 1. It falls one edge after `overtemp_i` drops. It never rises while in these states.
- R5: With `idle_state_i` = 11 (C7), `pin_pulldown_o` is 0 one edge later, even with `overtemp_i` at 1. After a return to 00 it follows R3 again.
- R6: A falling synchronized pin level gives a one-cycle `irq_assert_o` pulse on the third edge after `pin_in` falls, but only if `irq_assert_en_i` is 1. Otherwise `irq_assert_o` stays 0.
- R7: A rising synchronized pin level gives a one-cycle `irq_deassert_o` pulse on the third edge after `pin_in` rises, but only if `irq_deassert_en_i` is 1. Otherwise `irq_deassert_o` stays 0.
- R8: An edge seen while no window is open opens a window of 1500 `us_tick_i` ticks. An edge that occurs while the window is open sets `force_min_o`. This includes an edge in the very cycle in which the 1500th tick closes the window. With a tick on every cycle, a second `pin_in` change made 1500 cycles after the first sets `force_min_o`.
- R9: An edge arriving after the window has closed opens a new window and does not set `force_min_o`. With a tick on every cycle, a gap of 1501 cycles between `pin_in` changes leaves `force_min_o` at 0.
- R10: `force_min_o` stays 1 until `force_clr_i` is sampled high. A trip and a clear in the same cycle leave it at 1.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 1 | Sampled level of the shared hot pin, 0 = asserted |
| overtemp_i | input | 1 | Internal over-temperature flag |
| idle_state_i | input | 2 | Package idle state: 00 active, 01 C3, 10 C6, 11 C7 |
| irq_assert_en_i | input | 1 | Enable for the assertion-edge interrupt |
| irq_deassert_en_i | input | 1 | Enable for the release-edge interrupt |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| force_clr_i | input | 1 | Software clear of the forced-minimum latch |
| pin_pulldown_o | output | 1 | Drives the shared pin low when 1 |
| throttle_o | output | 1 | Throttle-control active |
| force_min_o | output | 1 | Latched lowest-performance-state request |
| irq_assert_o | output | 1 | Assertion-edge interrupt pulse |
| irq_deassert_o | output | 1 | Release-edge interrupt pulse |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the closing tick of the toggle window and a pin edge. The bench places the second pin change exactly 1500 and exactly 1501 cycles after the first, with a tick on every cycle. It expects a trip for the first gap and a fresh window without a trip for the second.

The second pair is a trip and a software clear. The bench raises `force_clr_i` for the very edge that registers the trip and expects `force_min_o` to remain 1.

// File: rtl/thm_pkg.sv
package thm_pkg;

  typedef enum logic [1:0] {
    PKG_ACTIVE = 2'b00,
    PKG_C3     = 2'b01,
    PKG_C6     = 2'b10,
    PKG_C7     = 2'b11
  } pkg_idle_e;

endpackage

// File: rtl/thm_reset_sync.sv
module thm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/thm_pin_sync.sv
module thm_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw_i,
  output logic pin_lvl_o,
  output logic fall_o,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  // first stage samples the raw pin; the rest form the chain (idle level is high)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b1;
    else        stage_q[0] <= pin_raw_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b1;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign pin_lvl_o = stage_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_lvl_o;
  end

  assign fall_o = prev_q & ~pin_lvl_o;
  assign rise_o = ~prev_q & pin_lvl_o;

endmodule

// File: rtl/thm_toggle_guard.sv
module thm_toggle_guard #(
  parameter int WINDOW_TICKS = 1500,
  parameter int TOGGLE_LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic force_o
);

  localparam int CNT_W  = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
  localparam int EDGE_W = $clog2(TOGGLE_LIMIT + 1);
  localparam logic [CNT_W-1:0]  LAST_TICK = CNT_W'(WINDOW_TICKS - 1);
  localparam logic [EDGE_W-1:0] EDGE_MAX  = EDGE_W'(TOGGLE_LIMIT);

  logic              open_q,  open_n;
  logic [CNT_W-1:0]  cnt_q,   cnt_n;
  logic [EDGE_W-1:0] edges_q, edges_n;
  logic              force_q, force_n;
  logic              trip;

  always_comb begin
    open_n  = open_q;
    cnt_n   = cnt_q;
    edges_n = edges_q;
    trip    = 1'b0;
    if (open_q) begin
      // edge check comes before closing, so an edge on the final tick still counts
      if (edge_i) begin
        if (edges_q >= EDGE_MAX) trip = 1'b1;
        else                     edges_n = edges_q + 1'b1;
      end
      if (tick_i) begin
        if (cnt_q == LAST_TICK) open_n = 1'b0;
        else                    cnt_n  = cnt_q + 1'b1;
      end
    end else if (edge_i) begin
      open_n  = 1'b1;
      cnt_n   = '0;
      edges_n = EDGE_W'(1);
    end
    force_n = trip | (force_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      cnt_q   <= '0;
      edges_q <= '0;
      force_q <= 1'b0;
    end else begin
      open_q  <= open_n;
      cnt_q   <= cnt_n;
      edges_q <= edges_n;
      force_q <= force_n;
    end
  end

  assign force_o = force_q;

endmodule

// File: rtl/thm_pin_hold.sv
module thm_pin_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] idle_i,
  input  logic       overtemp_i,
  output logic       pulldown_o
);

  import thm_pkg::*;

  logic      drive_q, drive_n;
  pkg_idle_e idle_st;

  assign idle_st = pkg_idle_e'(idle_i);

  always_comb begin
    unique case (idle_st)
      PKG_ACTIVE:     drive_n = overtemp_i;
      PKG_C3, PKG_C6: drive_n = drive_q & overtemp_i;
      PKG_C7:         drive_n = 1'b0;
      default:        drive_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= drive_n;
  end

  assign pulldown_o = drive_q;

endmodule

// File: rtl/thm_hot_pin_monitor.sv
module thm_hot_pin_monitor #(
  parameter int SYNC_STAGES  = 2,
  parameter int WINDOW_TICKS = 1500,
  parameter int TOGGLE_LIMIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       overtemp_i,
  input  logic [1:0] idle_state_i,
  input  logic       irq_assert_en_i,
  input  logic       irq_deassert_en_i,
  input  logic       us_tick_i,
  input  logic       force_clr_i,
  output logic       pin_pulldown_o,
  output logic       throttle_o,
  output logic       force_min_o,
  output logic       irq_assert_o,
  output logic       irq_deassert_o
);

  logic rst_int_n;
  logic pin_lvl, pin_fall, pin_rise, pin_edge;
  logic throttle_q, throttle_n;
  logic irq_a_q, irq_a_n;
  logic irq_d_q, irq_d_n;

  thm_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  thm_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_raw_i (pin_in),
    .pin_lvl_o (pin_lvl),
    .fall_o    (pin_fall),
    .rise_o    (pin_rise)
  );

  assign pin_edge = pin_fall | pin_rise;

  thm_toggle_guard #(
    .WINDOW_TICKS (WINDOW_TICKS),
    .TOGGLE_LIMIT (TOGGLE_LIMIT)
  ) u_guard (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .edge_i  (pin_edge),
    .tick_i  (us_tick_i),
    .clr_i   (force_clr_i),
    .force_o (force_min_o)
  );

  thm_pin_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .idle_i     (idle_state_i),
    .overtemp_i (overtemp_i),
    .pulldown_o (pin_pulldown_o)
  );

  always_comb begin
    throttle_n = overtemp_i | ~pin_lvl;
    irq_a_n    = pin_fall & irq_assert_en_i;
    irq_d_n    = pin_rise & irq_deassert_en_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      throttle_q <= 1'b0;
      irq_a_q    <= 1'b0;
      irq_d_q    <= 1'b0;
    end else begin
      throttle_q <= throttle_n;
      irq_a_q    <= irq_a_n;
      irq_d_q    <= irq_d_n;
    end
  end

  assign throttle_o     = throttle_q;
  assign irq_assert_o   = irq_a_q;
  assign irq_deassert_o = irq_d_q;

endmodule

// File: rtl/thm_monitor_checker.sv
module thm_monitor_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       overtemp_i,
  input logic [1:0] idle_state_i,
  input logic       irq_assert_en_i,
  input logic       irq_deassert_en_i,
  input logic       force_clr_i,
  input logic       pin_pulldown_o,
  input logic       throttle_o,
  input logic       force_min_o,
  input logic       irq_assert_o,
  input logic       irq_deassert_o
);

  AST_OT_THROTTLES: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp_i |=> throttle_o);  // R2

  AST_IDLE_NO_NEW_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((idle_state_i == 2'b01 || idle_state_i == 2'b10) && !pin_pulldown_o) |=> !pin_pulldown_o);  // R4

  AST_DEEP_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_state_i == 2'b11) |=> !pin_pulldown_o);  // R5

  AST_ASSERT_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_assert_en_i |=> !irq_assert_o);  // R6

  AST_ASSERT_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_assert_o |=> !irq_assert_o);  // R6

  AST_DEASSERT_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_deassert_en_i |=> !irq_deassert_o);  // R7

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_assert_o && irq_deassert_o));  // R7

  AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (force_min_o && !force_clr_i) |=> force_min_o);  // R10

endmodule

bind thm_hot_pin_monitor thm_monitor_checker u_checker (
  .clk               (clk),
  .rst_n             (rst_n),
  .overtemp_i        (overtemp_i),
  .idle_state_i      (idle_state_i),
  .irq_assert_en_i   (irq_assert_en_i),
  .irq_deassert_en_i (irq_deassert_en_i),
  .force_clr_i       (force_clr_i),
  .pin_pulldown_o    (pin_pulldown_o),
  .throttle_o        (throttle_o),
  .force_min_o       (force_min_o),
  .irq_assert_o      (irq_assert_o),
  .irq_deassert_o    (irq_deassert_o)
);

// File: tb/thm_hot_pin_monitor_test.sv
`timescale 1ns/1ps
module thm_hot_pin_monitor_test;

  logic       clk;
  logic       rst_n;
  logic       pin_in;
  logic       overtemp_i;
  logic [1:0] idle_state_i;
  logic       irq_assert_en_i;
  logic       irq_deassert_en_i;
  logic       us_tick_i;
  logic       force_clr_i;
  logic       pin_pulldown_o;
  logic       throttle_o;
  logic       force_min_o;
  logic       irq_assert_o;
  logic       irq_deassert_o;

  int n_checks;
  int n_fail;

  thm_hot_pin_monitor uut (
    .clk               (clk),
    .rst_n             (rst_n),
    .pin_in            (pin_in),
    .overtemp_i        (overtemp_i),
    .idle_state_i      (idle_state_i),
    .irq_assert_en_i   (irq_assert_en_i),
    .irq_deassert_en_i (irq_deassert_en_i),
    .us_tick_i         (us_tick_i),
    .force_clr_i       (force_clr_i),
    .pin_pulldown_o    (pin_pulldown_o),
    .throttle_o        (throttle_o),
    .force_min_o       (force_min_o),
    .irq_assert_o      (irq_assert_o),
    .irq_deassert_o    (irq_deassert_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // row layout: [3:2] idle state, [1] overtemp, [0] expected pull-down one edge later
  localparam logic [3:0] VEC [13] = '{
    4'b00_0_0, 4'b00_1_1, 4'b01_1_1, 4'b10_1_1, 4'b10_0_0,
    4'b10_1_0, 4'b00_1_1, 4'b11_1_0, 4'b01_1_0, 4'b00_0_0,
    4'b01_0_0, 4'b00_1_1, 4'b01_0_0
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail = 0;
    rst_n = 1'b0;
    pin_in = 1'b1;
    overtemp_i = 1'b0;
    idle_state_i = 2'b00;
    irq_assert_en_i = 1'b0;
    irq_deassert_en_i = 1'b0;
    us_tick_i = 1'b0;
    force_clr_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cycles(4);

    // R11 reset state
    check("R11 pulldown", pin_pulldown_o, 1'b0);
    check("R11 throttle", throttle_o, 1'b0);
    check("R11 force", force_min_o, 1'b0);
    check("R11 irq_assert", irq_assert_o, 1'b0);
    check("R11 irq_deassert", irq_deassert_o, 1'b0);

    // table walk: R3 active, R4 C3/C6 hold, R5 C7 release, R2 throttle from overtemp
    for (int i = 0; i < 13; i++) begin
      idle_state_i = VEC[i][3:2];
      overtemp_i   = VEC[i][1];
      cycles(1);
      if (VEC[i][3:2] == 2'b00)      check("R3 pulldown", pin_pulldown_o, VEC[i][0]);
      else if (VEC[i][3:2] == 2'b11) check("R5 pulldown", pin_pulldown_o, VEC[i][0]);
      else                           check("R4 pulldown", pin_pulldown_o, VEC[i][0]);
      check("R2 throttle", throttle_o, VEC[i][1]);
    end
    overtemp_i = 1'b0;
    idle_state_i = 2'b00;
    us_tick_i = 1'b1;
    cycles(2);

    // R1 / R6: external assertion, interrupts enabled
    irq_assert_en_i = 1'b1;
    irq_deassert_en_i = 1'b1;
    pin_in = 1'b0;
    cycles(2);
    check("R1 throttle before third edge", throttle_o, 1'b0);
    check("R6 irq_assert before third edge", irq_assert_o, 1'b0);
    cycles(1);
    check("R1 throttle on third edge", throttle_o, 1'b1);
    check("R6 irq_assert pulse", irq_assert_o, 1'b1);
    check("R7 no release irq on assertion", irq_deassert_o, 1'b0);
    cycles(1);
    check("R6 irq_assert single cycle", irq_assert_o, 1'b0);
    cycles(1600);
    check("R1 throttle held while pin low", throttle_o, 1'b1);

    // R7 release edge after window closed; R9 no trip
    pin_in = 1'b1;
    cycles(3);
    check("R7 irq_deassert pulse", irq_deassert_o, 1'b1);
    check("R1 throttle released", throttle_o, 1'b0);
    cycles(1);
    check("R7 irq_deassert single cycle", irq_deassert_o, 1'b0);
    check("R9 no trip across closed window", force_min_o, 1'b0);
    cycles(1600);

    // R6 / R7 gating
    irq_assert_en_i = 1'b0;
    pin_in = 1'b0;
    cycles(3);
    check("R6 irq_assert gated", irq_assert_o, 1'b0);
    check("R1 throttle with gated irq", throttle_o, 1'b1);
    cycles(1600);
    irq_deassert_en_i = 1'b0;
    pin_in = 1'b1;
    cycles(3);
    check("R7 irq_deassert gated", irq_deassert_o, 1'b0);
    cycles(1600);

    // R9: second change 1501 cycles after the first -> fresh window, no trip
    pin_in = 1'b0;
    repeat (1501) @(posedge clk);
    @(negedge clk);
    pin_in = 1'b1;
    cycles(4);
    check("R9 gap 1501 no trip", force_min_o, 1'b0);
    cycles(1600);

    // R8: second change 1500 cycles after the first -> edge on closing tick trips
    pin_in = 1'b0;
    repeat (1500) @(posedge clk);
    @(negedge clk);
    pin_in = 1'b1;
    cycles(4);
    check("R8 gap 1500 trips", force_min_o, 1'b1);
    cycles(1600);
    check("R10 force sticky", force_min_o, 1'b1);
    force_clr_i = 1'b1;
    cycles(1);
    force_clr_i = 1'b0;
    check("R10 clear", force_min_o, 1'b0);
    cycles(1600);

    // R8 fast toggle with R10 clear in the same cycle as the trip
    pin_in = 1'b0;
    cycles(3);
    pin_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    force_clr_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    force_clr_i = 1'b0;
    check("R10 trip wins over clear", force_min_o, 1'b1);
    cycles(2);
    check("R8 fast toggle latched", force_min_o, 1'b1);
    force_clr_i = 1'b1;
    cycles(1);
    force_clr_i = 1'b0;
    check("R10 clear after trip", force_min_o, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule